// File: doc/BRIEF.md
# Camera Bring-Up Register Sequencer

This block takes the place of the start-up software for a camera capture path. Once reset is released it works as a single-outstanding AXI4-Lite write master and issues a fixed, ordered list of register writes. First it gives a frame-buffer stream writer three buffer base addresses, then starts the writer and turns on its auto-restart. Next it arms the camera pixel interface. It then prepares an I2C master controller and configures the image sensor by pushing command words into that controller's transmit FIFO. Last, it clears the pixel interface's one-shot mode.

Each sensor register write takes four FIFO words. The first word carries a start request and the last carries a stop request. After the last word of each sensor write the sequencer waits a programmable number of clock cycles, so the I2C controller has time to drain its FIFO. When the list is finished the sequencer gives a one-cycle pulse and holds a done level. If a write returns an error response, the sequencer stops and holds an error flag. A restart request reruns the whole list, but only when the sequencer is idle.

Top module: `cam_bringup_seq`

## Requirements
- R1: The first three writes set the frame buffer addresses. Writer base + 0x18 gets FB, base + 0x20 gets FB + F, and base + 0x28 gets FB + 2F, where F = H_PIX * V_LINES * PIX_BYTES (default 800*600*4 = 1,920,000).
- R2: Writes four and five go to writer base + 0x00. The first carries 0x1, which starts the writer. The second carries 0x80, which turns on auto-restart.
- R3: Write six puts FB into camera-interface base + 0x0. The final write, number seventeen, puts 0 into camera-interface base + 0x4.
- R4: Writes seven and eight go to I2C base + 0x100. The first carries 0x2 to flush the transmit FIFO. The second carries 0x1 to enable the controller.
- R5: Each sensor register write is four writes to I2C base + 0x108, in this order:
  - 0x100 | (DEV & 0xFE), where bit 8 requests start.
  - The register number.
  - The value's high byte.
  - 0x200 | the value's low byte, where bit 9 requests stop.
  With DEV = 0xBA, the first pair is register 0xF0 with value 0x0001 and the second is register 0x97 with value 0x0020.
- R6: After the response to the last word of each sensor write, AWVALID stays low for at least GAP_CYC clock cycles.
- R7: AWVALID and WVALID each stay high, with AWADDR and WDATA stable, until their own handshake completes. The next write waits until the B handshake is done. WSTRB is always 0xF.
- R8: A non-zero BRESP sets a sticky err flag. After that no further write is issued.
- R9: In the cycle after the final B handshake, done rises and stays high, done_pulse is high for exactly one cycle, and busy falls.
- R10: A restart while done or err is high clears both flags and reruns the list from the first write. A restart while busy has no effect on the write sequence.
- R11: While in reset, all valid outputs, done, done_pulse and err are low. The first write starts by itself after reset with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Rerun request, accepted only when idle |
| m_awaddr | output | 32 | Write address |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | 32 | Write data |
| m_wstrb | output | 4 | Write byte strobes |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished without error |
| done_pulse | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky error response flag |

## Verification
The in-RTL assertions check the following on every cycle:
- AW and W channels hold their valid and payload while stalled.
- Response-ready never overlaps a pending address or data phase.
- The bus stays quiet during the post-sensor gap and after a fault.
- done_pulse is a single cycle that comes with the rise of done.

Only the bench's scenarios can show the content and order of the seventeen writes, the exact sensor word encoding, the minimum gap length, and the fact that a restart is ignored while busy but honoured after completion or after an error. The bench does this by comparing each captured write against a table built from the requirements, under several ready-latency patterns and an injected error response.

// File: rtl/cbs_pkg.sv
// Shared types and constants for the camera bring-up sequencer.
// Assumes a 32-bit AXI4-Lite address/data bus and two sensor transactions.
package cbs_pkg;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int STRB_W     = DATA_W / 8;
    localparam int N_SENS     = 2;
    localparam int PRE_STEPS  = 8;
    localparam int SENS_BASE  = PRE_STEPS;
    localparam int STEP_COUNT = PRE_STEPS + 4 * N_SENS + 1;
    localparam int IDX_W      = $clog2(STEP_COUNT);

    // Byte offsets inside each target's register window
    localparam logic [ADDR_W-1:0] OFS_BUF0   = 32'h18;
    localparam logic [ADDR_W-1:0] OFS_BUF1   = 32'h20;
    localparam logic [ADDR_W-1:0] OFS_BUF2   = 32'h28;
    localparam logic [ADDR_W-1:0] OFS_WCTRL  = 32'h00;
    localparam logic [ADDR_W-1:0] OFS_CARM   = 32'h00;
    localparam logic [ADDR_W-1:0] OFS_CSHOT  = 32'h04;
    localparam logic [ADDR_W-1:0] OFS_ICTRL  = 32'h100;
    localparam logic [ADDR_W-1:0] OFS_ITXQ   = 32'h108;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              gap;
    } step_t;

    typedef enum logic [2:0] {ST_ISSUE, ST_WAIT, ST_GAP, ST_DONE, ST_FAULT} seq_st_e;
    typedef enum logic [1:0] {BUS_IDLE, BUS_ADDR, BUS_RESP} bus_st_e;
endpackage

// File: rtl/cbs_step_table.sv
// Step table: maps a step index to the address, data and gap flag of
// one register write. Purely combinational; assumes idx < STEP_COUNT.
module cbs_step_table
    import cbs_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WR_BASE     = 32'hA001_0000,
    parameter logic [ADDR_W-1:0] CAM_BASE    = 32'hA000_0000,
    parameter logic [ADDR_W-1:0] IIC_BASE    = 32'hA000_1000,
    parameter logic [ADDR_W-1:0] FB_BASE     = 32'h1000_0000,
    parameter logic [ADDR_W-1:0] FRAME_BYTES = 32'd1920000,
    parameter logic [7:0]        DEV_ADDR    = 8'hBA,
    parameter logic [8*N_SENS-1:0]  SENS_REG = {8'h97, 8'hF0},
    parameter logic [16*N_SENS-1:0] SENS_VAL = {16'h0020, 16'h0001}
) (
    input  logic [IDX_W-1:0] idx,
    output step_t            step
);
    step_t tbl [STEP_COUNT];

    // Fixed preamble: buffer addresses, writer start, camera arm, I2C init
    assign tbl[0] = '{WR_BASE + OFS_BUF0, FB_BASE, 1'b0};
    assign tbl[1] = '{WR_BASE + OFS_BUF1, FB_BASE + FRAME_BYTES, 1'b0};
    assign tbl[2] = '{WR_BASE + OFS_BUF2, FB_BASE + 2 * FRAME_BYTES, 1'b0};
    assign tbl[3] = '{WR_BASE + OFS_WCTRL, 32'h1, 1'b0};
    assign tbl[4] = '{WR_BASE + OFS_WCTRL, 32'h80, 1'b0};
    assign tbl[5] = '{CAM_BASE + OFS_CARM, FB_BASE, 1'b0};
    assign tbl[6] = '{IIC_BASE + OFS_ICTRL, 32'h2, 1'b0};
    assign tbl[7] = '{IIC_BASE + OFS_ICTRL, 32'h1, 1'b0};

    // Four transmit-FIFO words per sensor register write
    for (genvar s = 0; s < N_SENS; s++) begin : g_sens
        localparam logic [7:0]  RNUM = SENS_REG[8*s +: 8];
        localparam logic [15:0] RVAL = SENS_VAL[16*s +: 16];
        assign tbl[SENS_BASE+4*s+0] = '{IIC_BASE + OFS_ITXQ, 32'h100 | {24'h0, DEV_ADDR & 8'hFE}, 1'b0};
        assign tbl[SENS_BASE+4*s+1] = '{IIC_BASE + OFS_ITXQ, {24'h0, RNUM}, 1'b0};
        assign tbl[SENS_BASE+4*s+2] = '{IIC_BASE + OFS_ITXQ, {24'h0, RVAL[15:8]}, 1'b0};
        assign tbl[SENS_BASE+4*s+3] = '{IIC_BASE + OFS_ITXQ, 32'h200 | {24'h0, RVAL[7:0]}, 1'b1};
    end

    // Final step: disable one-shot capture
    assign tbl[STEP_COUNT-1] = '{CAM_BASE + OFS_CSHOT, 32'h0, 1'b0};

    assign step = tbl[idx];
endmodule

// File: rtl/cbs_gap_timer.sv
// Gap timer: after load, raises expired once GAP_CYC-1 further edges
// have passed, then idles. Assumes GAP_CYC >= 1.
module cbs_gap_timer #(
    parameter int GAP_CYC = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CW = $clog2(GAP_CYC + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(GAP_CYC - 1);

    logic [CW-1:0] cnt;
    logic          running;

    assign expired = running && (cnt == '0);

    // Count down from the load value; stop on expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (load) begin
            cnt     <= LOAD_VAL;
            running <= 1'b1;
        end else if (expired) begin
            running <= 1'b0;
        end else if (running) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/cbs_axil_wr.sv
// Single-outstanding AXI4-Lite write engine. A go pulse (only taken
// when idle) launches AW and W together; each drops on its own
// handshake; then the B response is awaited and reported through fin.
module cbs_axil_wr
    import cbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] go_addr,
    input  logic [DATA_W-1:0] go_data,
    output logic              fin,
    output logic              fin_bad,
    output logic [ADDR_W-1:0] m_awaddr,
    output logic              m_awvalid,
    input  logic              m_awready,
    output logic [DATA_W-1:0] m_wdata,
    output logic [STRB_W-1:0] m_wstrb,
    output logic              m_wvalid,
    input  logic              m_wready,
    input  logic [1:0]        m_bresp,
    input  logic              m_bvalid,
    output logic              m_bready
);
    bus_st_e st;
    logic    aw_left, w_left;

    assign aw_left = m_awvalid && !m_awready;
    assign w_left  = m_wvalid && !m_wready;
    assign m_wstrb = '1;
    assign fin     = (st == BUS_RESP) && m_bvalid;
    assign fin_bad = fin && (m_bresp != 2'b00);

    // Channel state: launch, retire AW/W independently, await response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= BUS_IDLE;
            m_awaddr  <= '0;
            m_wdata   <= '0;
            m_awvalid <= 1'b0;
            m_wvalid  <= 1'b0;
            m_bready  <= 1'b0;
        end else begin
            case (st)
                BUS_IDLE: if (go) begin
                    m_awaddr  <= go_addr;
                    m_wdata   <= go_data;
                    m_awvalid <= 1'b1;
                    m_wvalid  <= 1'b1;
                    st        <= BUS_ADDR;
                end
                BUS_ADDR: begin
                    m_awvalid <= aw_left;
                    m_wvalid  <= w_left;
                    if (!aw_left && !w_left) begin
                        m_bready <= 1'b1;
                        st       <= BUS_RESP;
                    end
                end
                BUS_RESP: if (m_bvalid) begin
                    m_bready <= 1'b0;
                    st       <= BUS_IDLE;
                end
                default: st <= BUS_IDLE;
            endcase
        end
    end

    p_aw_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr)));
    p_w_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata)));
    p_resp_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
        m_bready |-> (!m_awvalid && !m_wvalid));
endmodule

// File: rtl/cam_bringup_seq.sv
// Camera bring-up sequencer top. Walks the step table once after reset,
// issuing each entry as an AXI4-Lite write, pausing GAP_CYC cycles after
// steps flagged with a gap, and ending in done or fault. Assumes the
// slave eventually answers every write.
module cam_bringup_seq
    import cbs_pkg::*;
#(
    parameter logic [31:0] WR_BASE   = 32'hA001_0000,
    parameter logic [31:0] CAM_BASE  = 32'hA000_0000,
    parameter logic [31:0] IIC_BASE  = 32'hA000_1000,
    parameter logic [31:0] FB_BASE   = 32'h1000_0000,
    parameter int          H_PIX     = 800,
    parameter int          V_LINES   = 600,
    parameter int          PIX_BYTES = 4,
    parameter logic [7:0]  DEV_ADDR  = 8'hBA,
    parameter int          GAP_CYC   = 100000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart,
    output logic [31:0] m_awaddr,
    output logic        m_awvalid,
    input  logic        m_awready,
    output logic [31:0] m_wdata,
    output logic [3:0]  m_wstrb,
    output logic        m_wvalid,
    input  logic        m_wready,
    input  logic [1:0]  m_bresp,
    input  logic        m_bvalid,
    output logic        m_bready,
    output logic        busy,
    output logic        done,
    output logic        done_pulse,
    output logic        err
);
    localparam logic [31:0]      FRAME_BYTES = 32'(H_PIX * V_LINES * PIX_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX    = IDX_W'(STEP_COUNT - 1);

    seq_st_e          st;
    logic [IDX_W-1:0] idx;
    step_t            step;
    logic             go, fin, fin_bad, gap_load, gap_expired;

    cbs_step_table #(
        .WR_BASE(WR_BASE), .CAM_BASE(CAM_BASE), .IIC_BASE(IIC_BASE),
        .FB_BASE(FB_BASE), .FRAME_BYTES(FRAME_BYTES), .DEV_ADDR(DEV_ADDR),
        .SENS_REG({8'h97, 8'hF0}), .SENS_VAL({16'h0020, 16'h0001})
    ) u_table (
        .idx (idx),
        .step(step)
    );

    cbs_axil_wr u_bus (
        .clk(clk), .rst_n(rst_n), .go(go), .go_addr(step.addr), .go_data(step.data),
        .fin(fin), .fin_bad(fin_bad),
        .m_awaddr(m_awaddr), .m_awvalid(m_awvalid), .m_awready(m_awready),
        .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid), .m_wready(m_wready),
        .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready)
    );

    cbs_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(gap_load), .expired(gap_expired)
    );

    assign go       = (st == ST_ISSUE);
    assign gap_load = (st == ST_WAIT) && fin && !fin_bad && (idx != LAST_IDX) && step.gap;
    assign busy     = (st != ST_DONE) && (st != ST_FAULT);

    // Sequence control: issue, await response, optional gap, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_ISSUE;
            idx        <= '0;
            done       <= 1'b0;
            done_pulse <= 1'b0;
            err        <= 1'b0;
        end else begin
            done_pulse <= 1'b0;
            case (st)
                ST_ISSUE: st <= ST_WAIT;
                ST_WAIT: if (fin) begin
                    if (fin_bad) begin
                        err <= 1'b1;
                        st  <= ST_FAULT;
                    end else if (idx == LAST_IDX) begin
                        done       <= 1'b1;
                        done_pulse <= 1'b1;
                        st         <= ST_DONE;
                    end else if (step.gap) begin
                        st <= ST_GAP;
                    end else begin
                        idx <= idx + 1'b1;
                        st  <= ST_ISSUE;
                    end
                end
                ST_GAP: if (gap_expired) begin
                    idx <= idx + 1'b1;
                    st  <= ST_ISSUE;
                end
                ST_DONE, ST_FAULT: if (restart) begin
                    idx  <= '0;
                    done <= 1'b0;
                    err  <= 1'b0;
                    st   <= ST_ISSUE;
                end
                default: st <= ST_FAULT;
            endcase
        end
    end

    p_gap_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_GAP) |-> (!m_awvalid && !m_wvalid));
    p_fault_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!m_awvalid && !m_wvalid));
    p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);
    p_pulse_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> done_pulse);
    p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
endmodule

// File: tb/sim_cam_bringup_seq.sv
`timescale 1ns/1ps
module sim_cam_bringup_seq;
    localparam int GAP = 40;
    localparam int NSTEP = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic [31:0] m_awaddr, m_wdata;
    logic        m_awvalid, m_wvalid, m_bready;
    logic [3:0]  m_wstrb;
    logic        m_awready = 1'b0, m_wready = 1'b0, m_bvalid = 1'b0;
    logic [1:0]  m_bresp = 2'b00;
    logic        busy, done, done_pulse, err;

    always #2.5 clk = ~clk;

    cam_bringup_seq #(.GAP_CYC(GAP)) u0 (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .m_awaddr(m_awaddr), .m_awvalid(m_awvalid), .m_awready(m_awready),
        .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid), .m_wready(m_wready),
        .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
        .busy(busy), .done(done), .done_pulse(done_pulse), .err(err)
    );

    int checks = 0, fails = 0, cyc = 0;
    int aw_lat = 0, w_lat = 0, err_en = 0, err_at = 0;
    int aw_wait = 0, w_wait = 0, k = 0, gap_mark = 0;
    bit aw_got = 0, w_got = 0, b_clear = 0, aw_prev = 0, gap_arm = 0;
    bit exp_done = 0, exp_err = 0, exp_pulse = 0;
    logic [31:0] cap_addr, cap_data;
    logic [3:0]  cap_strb;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Expected write list, written from the requirements
    function automatic logic [31:0] e_addr(input int i);
        case (i)
            0: return 32'hA001_0018;  1: return 32'hA001_0020;  2: return 32'hA001_0028;
            3, 4: return 32'hA001_0000;
            5: return 32'hA000_0000;
            6, 7: return 32'hA000_1100;
            16: return 32'hA000_0004;
            default: return 32'hA000_1108;
        endcase
    endfunction
    function automatic logic [31:0] e_data(input int i);
        case (i)
            0: return 32'h1000_0000;  1: return 32'h101D_4C00;  2: return 32'h103A_9800;
            3: return 32'h1;  4: return 32'h80;  5: return 32'h1000_0000;
            6: return 32'h2;  7: return 32'h1;
            8, 12: return 32'h1BA;
            9: return 32'hF0;  10: return 32'h00;  11: return 32'h201;
            13: return 32'h97; 14: return 32'h00;  15: return 32'h220;
            default: return 32'h0;
        endcase
    endfunction
    function automatic string e_req(input int i);
        if (i < 3) return "R1";
        if (i < 5) return "R2";
        if (i == 5 || i == 16) return "R3";
        if (i < 8) return "R4";
        return "R5";
    endfunction

    // Per-clock reference model and slave, evaluated away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog expired (R9) actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
        if (!rst_n) begin
            chk(!m_awvalid && !m_wvalid && !done && !err && !done_pulse, "R11 reset state",
                {m_awvalid, m_wvalid, done, err, done_pulse}, 0);
        end else begin
            chk(done == exp_done, "R9 done level", done, exp_done);
            chk(done_pulse == exp_pulse, "R9 done_pulse", done_pulse, exp_pulse);
            chk(err == exp_err, "R8 err flag", err, exp_err);
            chk(busy == !(exp_done || exp_err), "R9 busy", busy, !(exp_done || exp_err));
            if (exp_err) chk(!m_awvalid, "R8 no write after error", m_awvalid, 0);
            exp_pulse = 0;
            if (restart && (exp_done || exp_err)) begin
                exp_done = 0; exp_err = 0; k = 0;
            end
            if (m_awvalid && !aw_prev && gap_arm) begin
                chk(cyc - gap_mark >= GAP, "R6 gap length", cyc - gap_mark, GAP);
                gap_arm = 0;
            end
            aw_prev = m_awvalid;
            if (b_clear) begin m_bvalid = 0; b_clear = 0; end
            m_awready = 0;
            if (m_awvalid && !aw_got) begin
                if (aw_wait >= aw_lat) begin
                    m_awready = 1; aw_got = 1; cap_addr = m_awaddr; aw_wait = 0;
                end else aw_wait++;
            end
            m_wready = 0;
            if (m_wvalid && !w_got) begin
                if (w_wait >= w_lat) begin
                    m_wready = 1; w_got = 1; cap_data = m_wdata; cap_strb = m_wstrb; w_wait = 0;
                end else w_wait++;
            end
            if (aw_got && w_got && !m_bvalid) begin
                m_bvalid = 1;
                m_bresp = (err_en != 0 && k == err_at) ? 2'b10 : 2'b00;
            end
            if (m_bvalid && m_bready && !b_clear) begin
                chk(k < NSTEP, "R10 write count per pass", k, NSTEP - 1);
                chk(cap_addr == e_addr(k), {e_req(k), " address"}, cap_addr, e_addr(k));
                chk(cap_data == e_data(k), {e_req(k), " data"}, cap_data, e_data(k));
                chk(cap_strb == 4'hF, "R7 strobes", cap_strb, 4'hF);
                aw_got = 0; w_got = 0; b_clear = 1;
                if (m_bresp != 2'b00) exp_err = 1;
                else begin
                    if (k == 11 || k == 15) begin gap_mark = cyc; gap_arm = 1; end
                    k++;
                    if (k == NSTEP) begin exp_done = 1; exp_pulse = 1; end
                end
            end
        end
    end

    task automatic pulse_restart();
        @(posedge clk); #1 restart = 1;
        @(posedge clk); #1 restart = 0;
    endtask

    task automatic wait_flag(input bit want_err);
        while (!(want_err ? exp_err : exp_done)) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        @(posedge clk); #1 rst_n = 1;
        // Pass 1 (R11 auto start): ready at once
        wait_flag(0);
        chk(k == NSTEP, "R11 full pass after reset", k, NSTEP);
        // Pass 2 (R10, R7): AW stalls, restart while busy is ignored
        aw_lat = 2; w_lat = 0;
        pulse_restart();
        while (k != 12) @(negedge clk);
        pulse_restart();
        wait_flag(0);
        chk(k == NSTEP, "R10 busy restart ignored", k, NSTEP);
        // Pass 3 (R8): W stalls, error response on write 9
        aw_lat = 0; w_lat = 3; err_en = 1; err_at = 9;
        pulse_restart();
        wait_flag(1);
        repeat (30) @(negedge clk);
        chk(k == 9, "R8 sequence halted", k, 9);
        // Pass 4 (R10): restart after error, both channels stalled
        err_en = 0; aw_lat = 1; w_lat = 1;
        pulse_restart();
        wait_flag(0);
        chk(k == NSTEP, "R10 rerun after error", k, NSTEP);
        repeat (10) @(negedge clk);
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule